// File: doc/BRIEF.md
# Three-Wire Serial Control Register Writer

This block is the write-only control port of a mixed-signal front end. A host sends 16-bit words over three wires: an active-low select, a serial clock and a data line. While the select is low, each rising serial clock shifts one data bit in, most significant bit first. When the select returns high, the block checks the word. The word is split into a 2-bit operation code in bits 15:14, a 4-bit register address in bits 13:10 and a 10-bit payload in bits 9:0. If the word holds exactly 16 bits, carries the write opcode and names a defined address, the payload is stored in that one of seven 10-bit registers.

All three serial pins are brought into the system clock domain through flop synchronizers, so the port runs only from the system clock. The register contents are exported whole, and selected fields of the first two registers are decoded into control signals: input path, output disable, power down, clock and strobe polarity, and monitor source. The reset input is expected to be released synchronously to the system clock by the surrounding logic.

Top module: `sctl_port`

## Requirements
- R1: While reset is asserted and after it is released, all seven registers read zero and every decoded control output is zero.
- R2: A frame of exactly 16 bits with opcode 2'b01 (bits 15:14) and address A in 0..6 (bits 13:10) stores bits 9:0 into register A on the rising edge of select. No other register changes.
- R3: If select rises after fewer than 16 serial clock rising edges, no register changes.
- R4: If select rises after more than 16 serial clock rising edges, no register changes.
- R5: A 16-bit frame whose opcode is not 2'b01 leaves every register unchanged.
- R6: A 16-bit write frame to an address from 7 to 15 leaves every register unchanged.
- R7: The path select output follows bits 5:4 of register 0. 2'b00 gives 0 (off), 2'b01 gives 1 (direct input to gain stage), and 2'b1x gives 2 (alternate direct path), with bit 4 ignored.
- R8: The 2-bit monitor select output equals bits 1:0 of register 1 (0 off, 1 correlated-sample output, 2 gain-stage output, 3 reference/CCD input).
- R9: The converter clock invert output equals register 0 bit 6. The sample-hold clock invert output equals register 1 bit 2. The clamp/blanking invert output equals register 1 bit 3.
- R10: The output disable output equals register 0 bit 2, and the power down output equals register 0 bit 0.
- R11: A serial clock rising edge that reaches the synchronizers in the same cycle as the select release is not counted, so a 16-bit frame still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| csn_i | input | 1 | Serial select, active low, idle high |
| sck_i | input | 1 | Serial clock, data taken on its rising edge |
| sdi_i | input | 1 | Serial data, MSB first |
| regs_o | output | NUM_REGS*DATA_W (70) | Register contents, register k at bits k*DATA_W +: DATA_W |
| path_sel_o | output | 2 | Input path: 0 off, 1 gain stage, 2 alternate |
| out_dis_o | output | 1 | Data output disable |
| pwr_dn_o | output | 1 | Power down |
| clk_inv_o | output | 1 | Converter sampling clock polarity invert |
| sh_inv_o | output | 1 | Sample-hold clock polarity invert |
| clamp_inv_o | output | 1 | Clamp and blanking input polarity invert |
| mon_sel_o | output | 2 | Monitor source select |

## Verification
Two events can meet in one synchronized cycle: the commit caused by the select release and a serial clock rising edge that would otherwise count a seventeenth bit. The bench provokes this by driving a final serial clock rise in the same time step as the select rise, at the end of an otherwise valid 16-bit frame. It judges the result by the register contents read at the ports, which must show the write, as R11 requires. Random frames of many lengths, opcodes and addresses check the discard rules against a bench-side register model.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam logic [1:0] WR_OPCODE = 2'b01;

  // register indices whose fields are decoded
  localparam int MODE_A_IDX = 0;
  localparam int MODE_B_IDX = 1;

  // bit positions inside the first mode register
  localparam int MA_PWR_BIT  = 0;
  localparam int MA_ODIS_BIT = 2;
  localparam int MA_PATH_LO  = 4;
  localparam int MA_CKINV_BIT = 6;

  // bit positions inside the second mode register
  localparam int MB_MON_LO    = 0;
  localparam int MB_SHINV_BIT = 2;
  localparam int MB_CLINV_BIT = 3;

  typedef enum logic [1:0] {
    PATH_OFF  = 2'd0,
    PATH_GAIN = 2'd1,
    PATH_ALT  = 2'd2
  } path_sel_e;

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sctl_framer.sv
module sctl_framer
  import sctl_pkg::*;
#(
  parameter int OP_W     = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 10,
  parameter int NUM_REGS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sck_q, csn_q;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_base;
  logic               sck_rise, cs_rise;
  logic [OP_W-1:0]    op_f;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_rise  = csn_s & ~csn_q;

  always_comb begin
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    cnt_base = csn_q ? '0 : cnt_q;
    if (!csn_s) begin
      cnt_d = cnt_base;
      if (sck_rise) begin
        shreg_d = {shreg_q[FRAME_W-2:0], sdi_s};
        cnt_d   = (cnt_base == CNT_SAT) ? CNT_SAT : cnt_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sck_q   <= sck_s;
      csn_q   <= csn_s;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign op_f    = shreg_q[FRAME_W-1 -: OP_W];
  assign wr_addr = shreg_q[DATA_W +: ADDR_W];
  assign wr_data = shreg_q[DATA_W-1:0];
  assign wr_en   = cs_rise && (cnt_q == CNT_FULL) && (op_f == OP_W'(WR_OPCODE))
                   && ({1'b0, wr_addr} < (ADDR_W+1)'(NUM_REGS));

  // R4: the bit counter never runs past its saturation value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);

  // R3: a counter below full at the select release never yields a write
  p_short_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt_q < CNT_FULL) |-> !wr_en);

endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile #(
  parameter int NUM_REGS = 7,
  parameter int DATA_W   = 10,
  parameter int ADDR_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic [DATA_W-1:0] reg_d [NUM_REGS];

  // R6: the framer only presents defined addresses
  p_addr_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < (ADDR_W+1)'(NUM_REGS)));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(k));

    always_comb begin
      reg_d[k] = reg_q[k];
      if (hit) reg_d[k] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[k] <= '0;
      else        reg_q[k] <= reg_d[k];
    end

    assign regs_flat[k*DATA_W +: DATA_W] = reg_q[k];

    // R2: an accepted write lands in the addressed register
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(k)) |=> (reg_q[k] == $past(wr_data)));

    // R5: a register not addressed by an accepted write keeps its value
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(k)) |=> $stable(reg_q[k]));
  end

endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
(
  input  logic [1:0] ma_path,
  input  logic       ma_ckinv,
  input  logic       ma_odis,
  input  logic       ma_pwr,
  input  logic [1:0] mb_mon,
  input  logic       mb_shinv,
  input  logic       mb_clinv,
  output path_sel_e  path_sel,
  output logic       out_dis,
  output logic       pwr_dn,
  output logic       clk_inv,
  output logic       sh_inv,
  output logic       clamp_inv,
  output logic [1:0] mon_sel
);

  always_comb begin
    unique casez (ma_path)
      2'b00:   path_sel = PATH_OFF;
      2'b01:   path_sel = PATH_GAIN;
      default: path_sel = PATH_ALT;
    endcase
  end

  assign out_dis   = ma_odis;
  assign pwr_dn    = ma_pwr;
  assign clk_inv   = ma_ckinv;
  assign sh_inv    = mb_shinv;
  assign clamp_inv = mb_clinv;
  assign mon_sel   = mb_mon;

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int OP_W        = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 10,
  parameter int NUM_REGS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csn_i,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [1:0]                 path_sel_o,
  output logic                       out_dis_o,
  output logic                       pwr_dn_o,
  output logic                       clk_inv_o,
  output logic                       sh_inv_o,
  output logic                       clamp_inv_o,
  output logic [1:0]                 mon_sel_o
);

  localparam int MA_BASE = MODE_A_IDX * DATA_W;
  localparam int MB_BASE = MODE_B_IDX * DATA_W;

  logic [2:0]        pins_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  path_sel_e         path_e;

  sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({csn_i, sck_i, sdi_i}),
    .q     (pins_s)
  );

  sctl_framer #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn_s   (pins_s[2]),
    .sck_s   (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  sctl_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs_flat (regs_o)
  );

  sctl_decode u_dec (
    .ma_path   (regs_o[MA_BASE + MA_PATH_LO +: 2]),
    .ma_ckinv  (regs_o[MA_BASE + MA_CKINV_BIT]),
    .ma_odis   (regs_o[MA_BASE + MA_ODIS_BIT]),
    .ma_pwr    (regs_o[MA_BASE + MA_PWR_BIT]),
    .mb_mon    (regs_o[MB_BASE + MB_MON_LO +: 2]),
    .mb_shinv  (regs_o[MB_BASE + MB_SHINV_BIT]),
    .mb_clinv  (regs_o[MB_BASE + MB_CLINV_BIT]),
    .path_sel  (path_e),
    .out_dis   (out_dis_o),
    .pwr_dn    (pwr_dn_o),
    .clk_inv   (clk_inv_o),
    .sh_inv    (sh_inv_o),
    .clamp_inv (clamp_inv_o),
    .mon_sel   (mon_sel_o)
  );

  assign path_sel_o = path_e;

  // R7: upper path bit set forces the alternate path regardless of bit 4
  p_path_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[MA_BASE + MA_PATH_LO + 1] |-> (path_sel_o == 2'd2));

  // R8: monitor select tracks the second mode register
  p_mon_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_sel_o == regs_o[MB_BASE + MB_MON_LO +: 2]);

endmodule

// File: tb/sctl_port_test.sv
module sctl_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 7;
  localparam int DW = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [NREG*DW-1:0] regs;
  logic [1:0] path_sel, mon_sel;
  logic out_dis, pwr_dn, clk_inv, sh_inv, clamp_inv;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  sctl_port uut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
    .regs_o(regs), .path_sel_o(path_sel), .out_dis_o(out_dis), .pwr_dn_o(pwr_dn),
    .clk_inv_o(clk_inv), .sh_inv_o(sh_inv), .clamp_inv_o(clamp_inv), .mon_sel_o(mon_sel)
  );

  function automatic logic [1:0] exp_path(input logic [DW-1:0] m);
    return m[5] ? 2'd2 : (m[4] ? 2'd1 : 2'd0);
  endfunction

  function automatic bit frame_ok(input logic [15:0] w, input int nbits);
    return (nbits == 16) && (w[15:14] == 2'b01) && (w[13:10] < 4'd7);
  endfunction

  task automatic chk(input string tag, input logic [69:0] act, input logic [69:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NREG*DW-1:0] flat;
    for (int k = 0; k < NREG; k++) flat[k*DW +: DW] = model[k];
    chk(tag, 70'(regs), 70'(flat));
    chk("R7 path", 70'(path_sel), 70'(exp_path(model[0])));
    chk("R8 monitor", 70'(mon_sel), 70'(model[1][1:0]));
    chk("R9 polarity", 70'({clk_inv, sh_inv, clamp_inv}),
        70'({model[0][6], model[1][2], model[1][3]}));
    chk("R10 disable/power", 70'({out_dis, pwr_dn}), 70'({model[0][2], model[0][0]}));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends nbits serial clocks; bits beyond 16 carry zero
  task automatic send(input logic [15:0] w, input int nbits, input bit tail_edge);
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    if (tail_edge) sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
    wait_clk(8);
    if (frame_ok(w, nbits)) model[w[13:10]] = w[9:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int n;
    string tag;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    void'($urandom(32'd20240611));
    wait_clk(3);
    check_all("R1 reset held");
    rst_n = 1'b1;
    wait_clk(4);
    check_all("R1 after reset");

    // R2 basic writes to every defined register
    for (int a = 0; a < NREG; a++) begin
      send({2'b01, 4'(a), 10'($urandom)}, 16, 1'b0);
      check_all("R2 write");
    end
    // R7 all path codes
    for (int p = 0; p < 4; p++) begin
      send({2'b01, 4'd0, 4'b0000, 2'(p), 4'b0000}, 16, 1'b0);
      check_all("R7 path code");
    end
    // R8 all monitor codes, R9 polarity bits
    for (int m = 0; m < 4; m++) begin
      send({2'b01, 4'd1, 6'b000000, 2'(m), 2'(m)}, 16, 1'b0);
      check_all("R8 R9 mode two");
    end
    send({2'b01, 4'd0, 10'b0001000101}, 16, 1'b0);
    check_all("R9 R10 mode one");
    // R3 short frame, R4 long frame, R5 opcode, R6 address
    send({2'b01, 4'd2, 10'h3FF}, 15, 1'b0);
    check_all("R3 short frame");
    send({2'b01, 4'd2, 10'h155}, 17, 1'b0);
    check_all("R4 long frame");
    send({2'b11, 4'd3, 10'h2AA}, 16, 1'b0);
    check_all("R5 bad opcode");
    send({2'b01, 4'd7, 10'h3FF}, 16, 1'b0);
    check_all("R6 address seven");
    send({2'b01, 4'd15, 10'h3FF}, 16, 1'b0);
    check_all("R6 address fifteen");
    // R11 serial clock rise together with select release
    send({2'b01, 4'd4, 10'h2C3}, 16, 1'b1);
    check_all("R11 tail edge commit");

    // random frames
    for (int i = 0; i < 70; i++) begin
      w = 16'($urandom);
      if (($urandom % 3) != 0) w[15:14] = 2'b01;
      case ($urandom % 6)
        0: n = 1 + ($urandom % 15);
        1: n = 17 + ($urandom % 4);
        default: n = 16;
      endcase
      if (n < 16) tag = "R3 random short";
      else if (n > 16) tag = "R4 random long";
      else if (w[15:14] != 2'b01) tag = "R5 random opcode";
      else if (w[13:10] >= 4'd7) tag = "R6 random address";
      else tag = "R2 random write";
      send(w, n, 1'($urandom));
      check_all(tag);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule